// File: doc/BRIEF.md
# Submission Command Decoder with Compute Extensions

This block sits behind the submission-queue doorbell of a storage controller. When the host writes a new tail index into the doorbell, the block latches it and requests 64-byte command entries one at a time, starting at its head index, until the head catches up with the tail. Each fetched entry arrives on a valid/ready stream. It is split into fields and routed to one of two paths. Read and write commands go to the storage path with their starting logical block address. Vendor-range opcodes go to an in-storage compute engine: a load query, an engine enable, an engine disable and a task delivery whose parameters ride in the four trailing dwords.

Every accepted entry yields exactly one completion entry one cycle later. The completion carries the command identifier, a status code and the updated head index. Opcodes outside the supported set yield a completion with an invalid-opcode status and no decoded-command strobe. The block also holds a single engine-on flag, which the enable and disable commands set and clear.

Top module: `nvme_cmd_decoder`

## Requirements
- R1: Dword n of an entry occupies ent_data bits 32n+31 down to 32n. The opcode is bits 7:0 and the command identifier is bits 31:16.
- R2: Opcode 0x02 (read) gives cmd_kind 0 and opcode 0x01 (write) gives cmd_kind 1. For both, cmd_lba equals {dword 11, dword 10}, and cmd_valid pulses in the cycle after acceptance.
- R3: Opcodes 0x80, 0x81, 0x82 and 0x83 give cmd_kind 2 (load query), 3 (enable), 4 (disable) and 5 (task) respectively. cmd_param carries dwords 15 to 12 as {dw15, dw14, dw13, dw12}.
- R4: Any other opcode, including vendor opcodes above 0x83, raises no cmd_valid and completes with cpl_status 0x01. Supported opcodes complete with cpl_status 0x00.
- R5: Each accepted entry produces exactly one cpl_valid pulse, in the next cycle, with cpl_cid equal to the entry's command identifier.
- R6: A doorbell write latches db_tail. fetch_req is high exactly while the head differs from the latched tail, and ent_ready follows fetch_req.
- R7: The head advances by one per accepted entry and wraps to 0 after reaching qsize_m1. fetch_idx shows the head, and cpl_sqhd shows the head after the entry was consumed.
- R8: The enable command sets eng_on and the disable command clears it, both in the completion cycle. Other commands leave eng_on unchanged.
- R9: After reset, head and tail are 0, fetch_req, cmd_valid, cpl_valid and eng_on are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| qsize_m1 | input | QW | Last valid queue index (queue size minus one) |
| db_valid | input | 1 | Doorbell write strobe |
| db_tail | input | QW | Tail index written to the doorbell |
| fetch_req | output | 1 | An entry is pending at fetch_idx |
| fetch_idx | output | QW | Queue index of the next entry to fetch |
| ent_valid | input | 1 | Fetched entry present |
| ent_ready | output | 1 | Block accepts the entry |
| ent_data | input | 512 | 64-byte command entry |
| cmd_valid | output | 1 | Decoded command strobe |
| cmd_kind | output | 3 | Decoded command type |
| cmd_lba | output | 64 | Starting logical block address |
| cmd_param | output | 128 | Task parameters from trailing dwords |
| eng_on | output | 1 | Compute engine enabled |
| cpl_valid | output | 1 | Completion entry strobe |
| cpl_cid | output | 16 | Command identifier of the completion |
| cpl_status | output | 8 | Completion status code |
| cpl_sqhd | output | QW | Head index after consumption |

## Verification
fetch_req reacts to a doorbell write in the cycle after it. The decoded command, the completion, eng_on and the new head all appear one clock after the edge that accepts an entry. The bench drives each input on a falling edge, lets one rising edge pass, and samples on the next falling edge. It samples once more a cycle later to confirm that the completion pulse does not repeat. For the pending-entry checks, the bench rings a doorbell two entries ahead and watches fetch_req stay high after the first acceptance and drop after the second.

// File: rtl/nvme_cmd_decoder.sv
module nvme_cmd_decoder #(
  parameter int QW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] qsize_m1,
  input  logic          db_valid,
  input  logic [QW-1:0] db_tail,
  output logic          fetch_req,
  output logic [QW-1:0] fetch_idx,
  input  logic          ent_valid,
  output logic          ent_ready,
  input  logic [511:0]  ent_data,
  output logic          cmd_valid,
  output logic [2:0]    cmd_kind,
  output logic [63:0]   cmd_lba,
  output logic [127:0]  cmd_param,
  output logic          eng_on,
  output logic          cpl_valid,
  output logic [15:0]   cpl_cid,
  output logic [7:0]    cpl_status,
  output logic [QW-1:0] cpl_sqhd
);
  localparam logic [7:0] ST_OK  = 8'h00;
  localparam logic [7:0] ST_BAD = 8'h01;

  logic [QW-1:0] head, tail, head_nxt;
  logic          take, known;
  logic [2:0]    kind;
  logic [7:0]    opc;

  assign fetch_req = head != tail;
  assign fetch_idx = head;
  assign ent_ready = fetch_req;
  assign take      = ent_valid && ent_ready;
  assign opc       = ent_data[7:0];
  assign head_nxt  = (head == qsize_m1) ? '0 : head + 1'b1;

  always_comb begin
    known = 1'b1;
    kind  = 3'd0;
    case (opc)
      8'h02: kind = 3'd0;
      8'h01: kind = 3'd1;
      8'h80: kind = 3'd2;
      8'h81: kind = 3'd3;
      8'h82: kind = 3'd4;
      8'h83: kind = 3'd5;
      default: known = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head       <= '0;
      tail       <= '0;
      cmd_valid  <= 1'b0;
      cmd_kind   <= '0;
      cmd_lba    <= '0;
      cmd_param  <= '0;
      eng_on     <= 1'b0;
      cpl_valid  <= 1'b0;
      cpl_cid    <= '0;
      cpl_status <= '0;
      cpl_sqhd   <= '0;
    end else begin
      if (db_valid) tail <= db_tail;
      cpl_valid <= take;
      cmd_valid <= take && known;
      if (take) begin
        head       <= head_nxt;
        cpl_sqhd   <= head_nxt;
        cpl_cid    <= ent_data[31:16];
        cpl_status <= known ? ST_OK : ST_BAD;
        cmd_kind   <= kind;
        cmd_lba    <= ent_data[383:320];
        cmd_param  <= ent_data[511:384];
        if (opc == 8'h81) eng_on <= 1'b1;
        if (opc == 8'h82) eng_on <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/nvme_cmd_decoder_chk.sv
module nvme_cmd_decoder_chk #(
  parameter int QW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [QW-1:0] qsize_m1,
  input logic          fetch_req,
  input logic [QW-1:0] fetch_idx,
  input logic          ent_valid,
  input logic          ent_ready,
  input logic [511:0]  ent_data,
  input logic          cmd_valid,
  input logic          eng_on,
  input logic          cpl_valid,
  input logic [15:0]   cpl_cid,
  input logic [7:0]    cpl_status
);
  logic acc;
  assign acc = ent_valid && ent_ready;

  a_r5_cpl_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (cpl_valid && cpl_cid == $past(ent_data[31:16])));
  a_r5_no_spurious_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !cpl_valid);
  a_r4_cmd_implies_cpl: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> (cpl_valid && cpl_status == 8'h00));
  a_r4_bad_vendor: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ent_data[7:0] > 8'h83) |=> (!cmd_valid && cpl_status == 8'h01));
  a_r7_head_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && fetch_idx == qsize_m1) |=> fetch_idx == '0);
  a_r6_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    ent_ready |-> fetch_req);
  a_r8_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ent_data[7:0] == 8'h81) |=> eng_on);
  a_r8_disable: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && ent_data[7:0] == 8'h82) |=> !eng_on);
endmodule

bind nvme_cmd_decoder nvme_cmd_decoder_chk #(.QW(QW)) u_chk (
  .clk(clk), .rst_n(rst_n), .qsize_m1(qsize_m1), .fetch_req(fetch_req),
  .fetch_idx(fetch_idx), .ent_valid(ent_valid), .ent_ready(ent_ready),
  .ent_data(ent_data), .cmd_valid(cmd_valid), .eng_on(eng_on),
  .cpl_valid(cpl_valid), .cpl_cid(cpl_cid), .cpl_status(cpl_status)
);

// File: tb/nvme_cmd_decoder_tb.sv
module nvme_cmd_decoder_tb;
  localparam int QW = 6;
  localparam int NV = 9;
  localparam logic [7:0] OPS  [NV] = '{8'h02, 8'h01, 8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'hFF, 8'h05};
  localparam logic       VLD  [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
  localparam logic [2:0] KIND [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd0, 3'd0, 3'd0};
  localparam logic [7:0] STS  [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01};

  logic clk = 0, rst_n = 0;
  logic [QW-1:0] qsize_m1 = 6'd3;
  logic db_valid = 0;
  logic [QW-1:0] db_tail = '0;
  logic ent_valid = 0;
  logic [511:0] ent_data = '0;
  logic fetch_req, ent_ready, cmd_valid, eng_on, cpl_valid;
  logic [QW-1:0] fetch_idx, cpl_sqhd;
  logic [2:0] cmd_kind;
  logic [63:0] cmd_lba;
  logic [127:0] cmd_param;
  logic [15:0] cpl_cid;
  logic [7:0] cpl_status;

  int checks = 0, errors = 0;
  logic done = 0;
  logic [QW-1:0] eh = '0;
  logic e_eng = 0;

  always #2 clk = ~clk;

  nvme_cmd_decoder #(.QW(QW)) u_dut (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [QW-1:0] nxt(input logic [QW-1:0] h);
    return (h == qsize_m1) ? '0 : h + 1'b1;
  endfunction

  task automatic ring(input logic [QW-1:0] t);
    @(negedge clk); db_valid = 1; db_tail = t;
    @(negedge clk); db_valid = 0;
  endtask

  task automatic send(input logic [7:0] op, input logic [15:0] cid, input logic vld,
                      input logic [2:0] kind, input logic [7:0] st, input logic [31:0] seed);
    logic [511:0] d;
    d = '0;
    for (int i = 0; i < 16; i++) d[32*i +: 32] = seed ^ (32'h1111_0000 * i);
    d[7:0] = op; d[31:16] = cid;
    chk("R6 fetch_req pending", fetch_req, 1);
    chk("R7 fetch_idx", fetch_idx, eh);
    ent_valid = 1; ent_data = d;
    @(negedge clk); ent_valid = 0;
    eh = nxt(eh);
    if (op == 8'h81) e_eng = 1;
    if (op == 8'h82) e_eng = 0;
    chk("R5 cpl_valid", cpl_valid, 1);
    chk("R5 cpl_cid", cpl_cid, cid);
    chk("R4 cpl_status", cpl_status, st);
    chk("R4 cmd_valid", cmd_valid, vld);
    chk("R7 cpl_sqhd", cpl_sqhd, eh);
    chk("R8 eng_on", eng_on, e_eng);
    if (vld) begin
      chk("R3 cmd_kind", cmd_kind, kind);
      if (kind < 2) chk("R2 cmd_lba", cmd_lba, {d[383:352], d[351:320]});
      if (kind == 5) chk("R3 cmd_param", cmd_param, {d[511:480], d[479:448], d[447:416], d[415:384]});
      chk("R1 cid field", cpl_cid, d[31:16]);
    end
    @(negedge clk);
    chk("R5 single completion", cpl_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R9 fetch_req", fetch_req, 0);
    chk("R9 cmd_valid", cmd_valid, 0);
    chk("R9 cpl_valid", cpl_valid, 0);
    chk("R9 eng_on", eng_on, 0);
    chk("R9 fetch_idx", fetch_idx, 0);

    for (int i = 0; i < NV; i++) begin
      ring(nxt(eh));
      send(OPS[i], 16'hA000 + 16'(i), VLD[i], KIND[i], STS[i], 32'h0BAD_0000 + 32'(i * 7919));
      chk("R6 queue empty after drain", fetch_req, 0);
    end

    ring(nxt(nxt(eh)));
    send(8'h81, 16'h5151, 1, 3'd3, 8'h00, 32'h1234_5678);
    chk("R6 second entry still pending", fetch_req, 1);
    send(8'h83, 16'h5252, 1, 3'd5, 8'h00, 32'hCAFE_F00D);
    chk("R6 empty when head meets tail", fetch_req, 0);
    chk("R8 task leaves engine on", eng_on, 1);

    ent_valid = 1; ent_data = '0; ent_data[7:0] = 8'h02;
    @(negedge clk); ent_valid = 0;
    chk("R6 entry ignored while empty", cpl_valid, 0);
    chk("R6 head unchanged while empty", fetch_idx, eh);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule